// File: doc/BRIEF.md
# E1 CRC-4 Multiframe Synchronizer

This block sits behind an E1 basic frame aligner. For every received frame it is given the aligned timeslot 0 byte, a flag telling whether that frame is an alignment frame or a non-alignment frame, and the basic alignment status. From the first bit of timeslot 0 of the non-alignment frames it finds the 16-frame CRC-4 multiframe. One bit of the six-bit word 001011 arrives in each of six successive non-alignment frames. Once the block has locked, it numbers the frames of the multiframe and captures the two remote error indication bits (E bits). These bits report CRC-4 errors seen at the far end.

A small state machine holds three states. **HUNT** searches for the word at any phase. **VERIFY** holds a candidate phase and waits for the next word. **LOCKED** means sync is declared. It has these transitions:
- **FOUND** (HUNT to VERIFY): a complete word is seen.
- **CONFIRM** (VERIFY to LOCKED): the second word arrives exactly one multiframe later.
- **MISS** (VERIFY to HUNT): the second word is wrong.
- **LOSE** (LOCKED to HUNT): too many consecutive words are bad.
- **ABORT** (VERIFY or LOCKED to HUNT): basic alignment is lost.

While locked, each E bit that arrives as 0 produces a one-clock pulse for an external error counter.

Top module: `crc4_mf_sync`

## Requirements
- R1: After reset, `crc4_loss` is 1, `frame_num` is 0, `e1_bit` and `e2_bit` are 1, and both error pulses are 0.
- R2: The multiframe bit is `ts0_byte[7]`. Only strobes with `fas_frame`=0 feed the search. The bit carried in alignment frames (`fas_frame`=1) never produces a lock, whatever pattern it forms.
- R3: The search runs only while `bfa_locked`=1. In HUNT, the strobe that completes six successive non-alignment bits 0,0,1,0,1,1 (oldest first) moves the block to VERIFY. After that strobe, `frame_num` is 11 and `crc4_loss` is still 1.
- R4: In VERIFY, a second complete word ending on the strobe at which `frame_num` would become 11 again moves the block to LOCKED. After that strobe, `crc4_loss` is 0.
- R5: In VERIFY, a word that fails at that point returns the block to HUNT. After that strobe, `frame_num` is 0 and `crc4_loss` is 1.
- R6: Outside HUNT, `frame_num` advances by one on every `ts0_valid` strobe and wraps from 15 to 0. Frame 1 carries the first 0 of the word and frame 11 carries its last bit. Without a strobe, `frame_num` holds its value.
- R7: A clock edge with `bfa_locked`=0 forces HUNT. After that edge, `crc4_loss` is 1 and `frame_num` is 0. The partial search is discarded, so six fresh non-alignment bits are needed for a new lock.
- R8: In LOCKED, a single bad word is tolerated. `LOSS_WORDS` consecutive bad words (default 2) return the block to HUNT on the strobe that ends the last of them.
- R9: While the block is LOCKED and `bfa_locked`=1, the bit of frame 13 is latched into `e1_bit` and the bit of frame 15 into `e2_bit`. Otherwise both hold their values.
- R10: A latched E bit of 0 (far-end CRC-4 error) gives exactly one clock of `e1_err` or `e2_err` in the cycle after its strobe. A value of 1 (no error) gives no pulse. There are no pulses outside LOCKED, and none on a strobe whose edge also sees `bfa_locked`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ts0_valid | input | 1 | One-clock strobe per received frame |
| ts0_byte | input | 8 | Aligned timeslot 0 byte; bit 7 is the first bit on the line |
| fas_frame | input | 1 | 1 for an alignment frame, 0 for a non-alignment frame |
| bfa_locked | input | 1 | Basic frame alignment held |
| crc4_loss | output | 1 | 1 while the CRC-4 multiframe is lost or not acquired |
| frame_num | output | 4 | Frame number within the multiframe, 0 to 15 |
| e1_bit | output | 1 | Last E bit latched from frame 13 |
| e2_bit | output | 1 | Last E bit latched from frame 15 |
| e1_err | output | 1 | One-clock pulse when the frame 13 E bit is 0 |
| e2_err | output | 1 | One-clock pulse when the frame 15 E bit is 0 |

## Verification
The critical overlap is a loss of basic alignment that falls on the same clock edge as the frame 13 strobe carrying an E bit of 0. In that cycle, the restart of the search and the E-bit capture compete. The bench provokes this on purpose once it has locked, and it also drops alignment at random frames during a long random run. The expected result is `crc4_loss` at 1, `frame_num` at 0, no `e1_err` pulse, and an unchanged `e1_bit`. A second overlap is the word check at frame 11 coinciding with the sync decision itself. Corrupted words in VERIFY and in LOCKED exercise it, and a bench model that counts clean words predicts the result.

// File: rtl/crc4_mf_pkg.sv
package crc4_mf_pkg;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } mf_state_t;

    localparam int          MF_FRAMES   = 16;
    localparam int          FN_W        = $clog2(MF_FRAMES);
    localparam int          WORD_LEN    = 6;
    // oldest received bit sits in the MSB
    localparam logic [WORD_LEN-1:0] MF_WORD = 6'b001011;
    localparam int          WORD_END_FN = 11;
    localparam int          EBIT_FN0    = 13;
    localparam int          EBIT_STEP   = 2;
    localparam int          N_EBITS     = 2;
    localparam int          TS0_BIT1    = 7;

endpackage

// File: rtl/mf_word_shifter.sv
module mf_word_shifter
    import crc4_mf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic shift_en,
    input  logic bit_in,
    output logic match_now
);
    logic [WORD_LEN-1:0] hist_q;

    // cleared to ones: the word starts with 0,0 so stale ones never match
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hist_q <= '1;
        else if (clear)
            hist_q <= '1;
        else if (shift_en)
            hist_q <= {hist_q[WORD_LEN-2:0], bit_in};
    end

    assign match_now = ({hist_q[WORD_LEN-2:0], bit_in} == MF_WORD);

endmodule

// File: rtl/mf_frame_counter.sv
module mf_frame_counter
    import crc4_mf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            zero,
    input  logic            load,
    input  logic            step,
    output logic [FN_W-1:0] fn,
    output logic [FN_W-1:0] fn_next
);
    logic [FN_W-1:0] fn_q;

    assign fn_next = fn_q + FN_W'(1);
    assign fn      = fn_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            fn_q <= '0;
        else if (zero)
            fn_q <= '0;
        else if (load)
            fn_q <= FN_W'(WORD_END_FN);
        else if (step)
            fn_q <= fn_next;
    end

endmodule

// File: rtl/ebit_capture.sv
module ebit_capture
    import crc4_mf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               strobe,
    input  logic [FN_W-1:0]    fn_next,
    input  logic               bit_in,
    output logic [N_EBITS-1:0] ebit,
    output logic [N_EBITS-1:0] eerr
);
    for (genvar i = 0; i < N_EBITS; i++) begin : g_ebit
        localparam logic [FN_W-1:0] POS = FN_W'(EBIT_FN0 + EBIT_STEP * i);
        logic hit;
        logic bit_q;
        logic err_q;

        assign hit = enable && strobe && (fn_next == POS);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bit_q <= 1'b1;
                err_q <= 1'b0;
            end else begin
                err_q <= hit && !bit_in;
                if (hit)
                    bit_q <= bit_in;
            end
        end

        assign ebit[i] = bit_q;
        assign eerr[i] = err_q;
    end

endmodule

// File: rtl/crc4_mf_sync.sv
module crc4_mf_sync
    import crc4_mf_pkg::*;
#(
    parameter int LOSS_WORDS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ts0_valid,
    input  logic [7:0] ts0_byte,
    input  logic       fas_frame,
    input  logic       bfa_locked,
    output logic       crc4_loss,
    output logic [3:0] frame_num,
    output logic       e1_bit,
    output logic       e2_bit,
    output logic       e1_err,
    output logic       e2_err
);
    localparam int BAD_W = $clog2(LOSS_WORDS + 1);

    mf_state_t state_q, state_d;

    logic            line_bit;
    logic            nfas_strobe;
    logic            word_point;
    logic            word_good;
    logic            match_now;
    logic [FN_W-1:0] fn, fn_next;
    logic [BAD_W-1:0] bad_q;
    logic            cnt_zero, cnt_load, shift_clear, shift_en, ecap_en;
    logic [N_EBITS-1:0] ebit, eerr;

    assign line_bit    = ts0_byte[TS0_BIT1];
    assign nfas_strobe = ts0_valid && !fas_frame;
    assign word_point  = ts0_valid && (fn_next == FN_W'(WORD_END_FN));
    assign word_good   = nfas_strobe && match_now;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (bfa_locked && word_good)
                    state_d = ST_VERIFY;                       // FOUND
            end
            ST_VERIFY: begin
                if (!bfa_locked)
                    state_d = ST_HUNT;                         // ABORT
                else if (word_point)
                    state_d = word_good ? ST_LOCKED : ST_HUNT; // CONFIRM / MISS
            end
            ST_LOCKED: begin
                if (!bfa_locked)
                    state_d = ST_HUNT;                         // ABORT
                else if (word_point && !word_good &&
                         bad_q == BAD_W'(LOSS_WORDS - 1))
                    state_d = ST_HUNT;                         // LOSE
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_HUNT;
        else
            state_q <= state_d;
    end

    // consecutive bad-word count while locked
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bad_q <= '0;
        else if (state_d != ST_LOCKED)
            bad_q <= '0;
        else if (word_point)
            bad_q <= word_good ? '0 : bad_q + BAD_W'(1);
    end

    // outputs and datapath controls
    always_comb begin
        crc4_loss   = (state_q != ST_LOCKED);
        cnt_zero    = (state_d == ST_HUNT);
        cnt_load    = (state_q == ST_HUNT) && (state_d == ST_VERIFY);
        shift_clear = !bfa_locked;
        shift_en    = nfas_strobe;
        ecap_en     = (state_q == ST_LOCKED) && bfa_locked;
    end

    mf_word_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (shift_clear),
        .shift_en  (shift_en),
        .bit_in    (line_bit),
        .match_now (match_now)
    );

    mf_frame_counter u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .zero    (cnt_zero),
        .load    (cnt_load),
        .step    (ts0_valid),
        .fn      (fn),
        .fn_next (fn_next)
    );

    ebit_capture u_ecap (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (ecap_en),
        .strobe  (ts0_valid),
        .fn_next (fn_next),
        .bit_in  (line_bit),
        .ebit    (ebit),
        .eerr    (eerr)
    );

    assign frame_num = fn;
    assign e1_bit    = ebit[0];
    assign e2_bit    = ebit[1];
    assign e1_err    = eerr[0];
    assign e2_err    = eerr[1];

endmodule

// File: rtl/crc4_mf_sync_chk.sv
module crc4_mf_sync_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ts0_valid,
    input logic       fas_frame,
    input logic       bfa_locked,
    input logic       crc4_loss,
    input logic [3:0] frame_num,
    input logic       e1_bit,
    input logic       e2_bit,
    input logic       e1_err,
    input logic       e2_err
);
    AST_BFA_DROP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !bfa_locked |=> (crc4_loss && frame_num == 4'd0)); // R7

    AST_LOCK_AT_WORD_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(crc4_loss) |-> (frame_num == 4'd11)); // R4

    AST_LOCK_NEEDS_NFAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(crc4_loss) |-> $past(ts0_valid && !fas_frame)); // R2

    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ts0_valid && bfa_locked) |=> $stable(frame_num)); // R6

    AST_ERR_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (e1_err || e2_err) |-> !crc4_loss); // R10

    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(e1_err && e2_err)); // R10

    AST_ERR_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (e1_err || e2_err) |-> $past(ts0_valid)); // R10

    AST_E1_MATCHES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        e1_err |-> !e1_bit); // R9

    AST_E2_MATCHES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        e2_err |-> !e2_bit); // R9

endmodule

bind crc4_mf_sync crc4_mf_sync_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ts0_valid  (ts0_valid),
    .fas_frame  (fas_frame),
    .bfa_locked (bfa_locked),
    .crc4_loss  (crc4_loss),
    .frame_num  (frame_num),
    .e1_bit     (e1_bit),
    .e2_bit     (e2_bit),
    .e1_err     (e1_err),
    .e2_err     (e2_err)
);

// File: tb/crc4_mf_sync_test.sv
module crc4_mf_sync_test;
    localparam int CLK_PERIOD = 10;
    localparam int LOSS_WORDS = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ts0_valid = 1'b0;
    logic [7:0] ts0_byte = 8'h00;
    logic       fas_frame = 1'b0;
    logic       bfa_locked = 1'b0;
    logic       crc4_loss;
    logic [3:0] frame_num;
    logic       e1_bit, e2_bit, e1_err, e2_err;

    int checks = 0;
    int errors = 0;

    // bench model state
    int f = 0;          // frame index of the next transmitted frame
    int nf = 0;         // non-alignment frames since alignment returned
    int words = 0;      // clean words seen while hunting/verifying
    int bad = 0;        // consecutive bad words while locked
    bit insync = 0;
    bit wordbad = 0;
    logic e1x = 1'b1, e2x = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    crc4_mf_sync #(.LOSS_WORDS(LOSS_WORDS)) uut (
        .clk(clk), .rst_n(rst_n), .ts0_valid(ts0_valid), .ts0_byte(ts0_byte),
        .fas_frame(fas_frame), .bfa_locked(bfa_locked), .crc4_loss(crc4_loss),
        .frame_num(frame_num), .e1_bit(e1_bit), .e2_bit(e2_bit),
        .e1_err(e1_err), .e2_err(e2_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (frame %0d)", req, act, exp, f);
        end
    endtask

    function automatic bit word_bit(input int idx);
        bit [5:0] w = 6'b001011;
        return w[5 - idx];
    endfunction

    function automatic int exp_frame();
        return (insync || words == 1) ? f : 0;
    endfunction

    // send one frame with the full reference model and checks
    task automatic tx(input bit corrupt, input bit bfa_v, input bit ev1, input bit ev2);
        bit fas, b, prev_in, clean, was_verify;
        bit p1, p2;
        int idx;
        fas = (f % 2 == 0);
        if (fas) b = 1'($urandom);
        else begin
            idx = (f - 1) / 2;
            if (idx < 6)       b = word_bit(idx) ^ corrupt;
            else if (idx == 6) b = ev1;
            else               b = ev2;
        end
        repeat ($urandom_range(0, 2)) @(negedge clk);
        ts0_valid  = 1'b1;
        ts0_byte   = {b, 7'($urandom)};
        fas_frame  = fas;
        bfa_locked = bfa_v;
        @(negedge clk);
        ts0_valid = 1'b0;

        prev_in = insync; was_verify = (words == 1) && !insync;
        p1 = 0; p2 = 0;
        if (f == 1) wordbad = 0;
        if (!bfa_v) begin
            nf = 0; words = 0; insync = 0; bad = 0; wordbad = 0;
        end else begin
            if (!fas) nf++;
            if (corrupt && !fas) wordbad = 1;
            if (f == 11) begin
                clean = (nf >= 6) && !wordbad;
                if (insync) begin
                    if (clean) bad = 0;
                    else begin
                        bad++;
                        if (bad == LOSS_WORDS) begin insync = 0; words = 0; bad = 0; end
                    end
                end else if (clean) begin
                    words++;
                    if (words == 2) begin insync = 1; bad = 0; end
                end else words = 0;
            end
            if (prev_in && f == 13) begin e1x = b; p1 = !b; end
            if (prev_in && f == 15) begin e2x = b; p2 = !b; end
        end

        if (!bfa_v)
            chk("R7 restart", {crc4_loss, frame_num}, {1'b1, 4'd0});
        else if (was_verify && f == 11 && !insync)
            chk("R5 verify miss", {crc4_loss, frame_num}, {1'b1, 4'd0});
        else if (words == 1 && f == 11)
            chk("R3 word found", {crc4_loss, frame_num}, {1'b1, 4'd11});
        else if (prev_in && insync && bad == 1 && f == 11)
            chk("R8 one bad word tolerated", crc4_loss, 0);
        chk("R4 sync flag", crc4_loss, !insync);
        chk("R6 frame number", frame_num, exp_frame());
        chk("R9 e1 latch", e1_bit, e1x);
        chk("R9 e2 latch", e2_bit, e2x);
        chk("R10 e1 pulse", e1_err, p1);
        chk("R10 e2 pulse", e2_err, p2);
        @(negedge clk);
        chk("R10 pulse width", {e1_err, e2_err}, 0);
        chk("R6 hold without strobe", frame_num, exp_frame());
        f = (f + 1) % 16;
    endtask

    task automatic run_frames(input int n);
        for (int i = 0; i < n; i++)
            tx(1'b0, 1'b1, 1'($urandom), 1'($urandom));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h5eed_c4c4));
        repeat (3) @(negedge clk);
        chk("R1 loss at reset", crc4_loss, 1);
        chk("R1 frame at reset", frame_num, 0);
        chk("R1 e bits at reset", {e1_bit, e2_bit}, 2'b11);
        chk("R1 pulses at reset", {e1_err, e2_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: word pattern only on alignment frames, ones on the others
        bfa_locked = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            ts0_valid = 1'b1;
            fas_frame = (i % 2 == 0);
            ts0_byte  = {(i % 2 == 0) ? word_bit((i / 2) % 6) : 1'b1, 7'h15};
            @(negedge clk);
            ts0_valid = 1'b0;
        end
        @(negedge clk);
        chk("R2 alignment-frame bits ignored", {crc4_loss, frame_num}, {1'b1, 4'd0});

        // random phase, lock and run
        f = int'($urandom_range(0, 15));
        nf = 0;
        run_frames(16 * 8);

        // one bad word tolerated, then two consecutive lose sync
        while (f != 5) run_frames(1);
        tx(1'b1, 1'b1, 1'b1, 1'b1);
        run_frames(16);
        while (f != 5) run_frames(1);
        tx(1'b1, 1'b1, 1'b0, 1'b0);
        while (f != 5) run_frames(1);
        tx(1'b1, 1'b1, 1'b0, 1'b1);
        chk("R8 still locked before word end", crc4_loss, 0);
        run_frames(12);
        chk("R8 lost after two bad words", crc4_loss, 1);

        // verify failure
        while (!(words == 1 && f == 5)) run_frames(1);
        tx(1'b1, 1'b1, 1'b0, 1'b0);
        run_frames(16 * 4);

        // alignment drop on the frame 13 strobe with E1 = 0
        while (!(insync && f == 13)) run_frames(1);
        tx(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R10 no pulse on drop", e1_err, 0);
        run_frames(16 * 4);

        // constrained random run
        for (int i = 0; i < 400; i++) begin
            bit dropb = ($urandom_range(0, 99) < 2);
            bit corr  = (f == 5) && ($urandom_range(0, 99) < 20);
            tx(corr, !dropb, 1'($urandom), 1'($urandom));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule